// File: doc/BRIEF.md
# Indexed-Colour Frame Scanout with Update-Region Grouping

This block walks a frame of 8-bit palette indices held row-major in video memory and turns each index into a 24-bit colour through an external palette lookup port. Each converted pixel leaves on a 32-bit output stream together with its linear frame address. Before it converts a row, the block asks whether that row needs redrawing. A row is redrawn when a frame-wide refresh flag is set or when the external per-row dirty bit for that row is set. Rows that need no redraw are skipped: no memory read and no palette lookup are made for them.

Consecutive redrawn rows are grouped into update regions. Each region is reported as a first row and a row count on a valid/ready port, so a downstream display path can copy just the changed bands. A pass begins on a start pulse and keeps a busy flag high until a one-cycle end-of-frame pulse. That pulse is meant to drive vertical-sync interrupt logic. The frame-wide refresh flag is set out of reset or by request, and it is dropped once a pass completes.

Video memory and the palette are both modelled as one-cycle-latency reads. The frame width and height are parameters.

Top module: `palScan`

## Requirements
- R1: Each output pixel is the word {8'h00, red[7:0], green[7:0], blue[7:0]}. Red, green and blue are the palette entry for the byte read at the same frame address. pixAddr equals row*WIDTH+column, and pixels leave in increasing address order.
- R2: A row is converted exactly when the refresh-all flag is set or rowDirty is high while rowSel shows that row.
- R3: A skipped row causes no vmRd and no palRd for any of its addresses. Later rows still use their full row*WIDTH base address.
- R4: A run of converted rows opens at its first converted row and closes at the next skipped row. It is then reported once as regStart (the first row) and regCount (the number of rows).
- R5: A run still open after the last row is reported as a final region before eof.
- R6: A region is transferred when regValid and regReady are both high at a clock edge. Until then, regValid, regStart and regCount stay unchanged and no vmRd is issued.
- R7: The refresh-all flag is set by reset and by a refreshAll pulse, and it is cleared at the end of a completed pass. A later pass with no dirty rows therefore converts nothing and reports no region.
- R8: A start pulse while idle begins a pass. busy reads high from the cycle after start through the eof cycle and low in the cycle after eof. eof lasts one cycle. A start pulse while busy is ignored.
- R9: eof is raised only after every pixel of the pass has left the output stream and every region has been transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (ignored while busy) |
| refreshAll | input | 1 | Force the next pass to convert every row |
| rowSel | output | ROW_W | Row whose dirty bit is being queried |
| rowDirty | input | 1 | Dirty bit for rowSel |
| vmRd | output | 1 | Video memory read request |
| vmAddr | output | VA_W | Video memory byte address |
| vmData | input | 8 | Read data, one cycle after vmRd |
| palRd | output | 1 | Palette lookup request |
| palIdx | output | 8 | Palette index |
| palRgb | input | 24 | Palette colour, one cycle after palRd |
| pixValid | output | 1 | Output pixel strobe |
| pixAddr | output | VA_W | Frame address of the output pixel |
| pixData | output | 32 | Packed output pixel |
| regValid | output | 1 | Update region available |
| regReady | input | 1 | Update region accepted |
| regStart | output | ROW_W | First row of the region |
| regCount | output | ROW_W | Number of rows in the region |
| busy | output | 1 | Pass in progress |
| eof | output | 1 | End-of-frame pulse |

## Verification
The hardest situation to reach is a region waiting on a slow consumer at the same moment the scan wants to move on. This happens both when a clean row closes a run in mid-frame and when a run reaches the last row and must be flushed before the pipeline drains. The bench sweeps every dirty-row pattern of a six-row frame. It varies how many cycles regReady is held back, so that each run shape meets both immediate and delayed acceptance. Passes with the refresh-all flag set, freshly cleared and set again by request show the flag's effect through the pixel and region streams.

// File: rtl/palScanPkg.sv
package palScanPkg;

  // Strobes from the control FSM to the datapath, one cycle each.
  typedef struct packed {
    logic clear;     // rewind counters and drop any open run
    logic issue;     // read one pixel and advance the column
    logic markRow;   // current row is converted: open or extend run
    logic skipRow;   // current row is clean: advance row only
    logic closeRun;  // move the open run into the region output
  } scanStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PIXELS,
    ST_DRAIN,
    ST_FINISH
  } scanState_t;

endpackage

// File: rtl/palScanDatapath.sv
module palScanDatapath
  import palScanPkg::*;
#(
  parameter int WIDTH  = 640,
  parameter int HEIGHT = 480,
  localparam int PIX_TOTAL = WIDTH * HEIGHT,
  localparam int VA_W   = (PIX_TOTAL > 1) ? $clog2(PIX_TOTAL) : 1,
  localparam int BASE_W = $clog2(PIX_TOTAL + 1),
  localparam int ROW_W  = $clog2(HEIGHT + 1),
  localparam int COL_W  = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobe_t       strobe,
  output logic              lastCol,
  output logic              rowsDone,
  output logic              runOpen,
  output logic              regPending,
  output logic              pipeEmpty,
  output logic [ROW_W-1:0]  rowSel,
  output logic              vmRd,
  output logic [VA_W-1:0]   vmAddr,
  input  logic [7:0]        vmData,
  output logic              palRd,
  output logic [7:0]        palIdx,
  input  logic [23:0]       palRgb,
  output logic              pixValid,
  output logic [VA_W-1:0]   pixAddr,
  output logic [31:0]       pixData,
  input  logic              regReady,
  output logic [ROW_W-1:0]  regStart,
  output logic [ROW_W-1:0]  regCount
);

  // ---------------- position counters ----------------
  logic [COL_W-1:0]  colCnt;
  logic [ROW_W-1:0]  rowCnt;
  logic [BASE_W-1:0] rowBase;
  logic [BASE_W-1:0] addrSum;
  logic              advanceRow;

  assign lastCol    = (colCnt == COL_W'(WIDTH - 1));
  assign rowsDone   = (rowCnt == ROW_W'(HEIGHT));
  assign advanceRow = strobe.skipRow | (strobe.issue & lastCol);
  assign rowSel     = rowCnt;
  assign addrSum    = rowBase + BASE_W'(colCnt);
  assign vmAddr     = addrSum[VA_W-1:0];
  assign vmRd       = strobe.issue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt  <= '0;
      rowCnt  <= '0;
      rowBase <= '0;
    end else if (strobe.clear) begin
      colCnt  <= '0;
      rowCnt  <= '0;
      rowBase <= '0;
    end else begin
      if (strobe.issue) begin
        colCnt <= lastCol ? '0 : colCnt + COL_W'(1);
      end
      if (advanceRow) begin
        rowCnt  <= rowCnt + ROW_W'(1);
        rowBase <= rowBase + BASE_W'(WIDTH);
      end
    end
  end

  // ---------------- pixel pipeline ----------------
  // stage 1: memory byte returns and goes straight to the palette port
  // stage 2: palette colour returns and is packed onto the stream
  logic            s1Valid, s2Valid;
  logic [VA_W-1:0] s1Addr, s2Addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
      s1Addr  <= '0;
      s2Addr  <= '0;
    end else begin
      s1Valid <= strobe.issue;
      s2Valid <= s1Valid;
      if (strobe.issue) s1Addr <= vmAddr;
      if (s1Valid)      s2Addr <= s1Addr;
    end
  end

  assign palRd     = s1Valid;
  assign palIdx    = vmData;
  assign pixValid  = s2Valid;
  assign pixAddr   = s2Addr;
  assign pixData   = {8'h00, palRgb};
  assign pipeEmpty = !s1Valid && !s2Valid && !strobe.issue;

  // ---------------- dirty-run tracker and region output ----------------
  logic [ROW_W-1:0] runStart, runCount;
  logic [ROW_W-1:0] regStartR, regCountR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runOpen  <= 1'b0;
      runStart <= '0;
      runCount <= '0;
    end else if (strobe.clear || strobe.closeRun) begin
      runOpen  <= 1'b0;
    end else if (strobe.markRow) begin
      if (!runOpen) begin
        runOpen  <= 1'b1;
        runStart <= rowCnt;
        runCount <= ROW_W'(1);
      end else begin
        runCount <= runCount + ROW_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regPending <= 1'b0;
      regStartR  <= '0;
      regCountR  <= '0;
    end else if (strobe.closeRun) begin
      regPending <= 1'b1;
      regStartR  <= runStart;
      regCountR  <= runCount;
    end else if (regPending && regReady) begin
      regPending <= 1'b0;
    end
  end

  assign regStart = regStartR;
  assign regCount = regCountR;

  AST_REGION_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    regPending && !regReady |=> regPending && $stable(regStartR) && $stable(regCountR)); // R6

  AST_REGION_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    regPending |-> (regCountR != '0) &&
      (({1'b0, regStartR} + {1'b0, regCountR}) <= (ROW_W + 1)'(HEIGHT))); // R4

  AST_ISSUE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> !rowsDone); // R3

endmodule

// File: rtl/palScanCtrl.sv
module palScanCtrl
  import palScanPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        refreshAll,
  input  logic        rowDirty,
  input  logic        lastCol,
  input  logic        rowsDone,
  input  logic        runOpen,
  input  logic        regPending,
  input  logic        pipeEmpty,
  output scanStrobe_t strobe,
  output logic        busy,
  output logic        eof
);

  scanState_t state, stateNext;
  logic       fullFlag;
  logic       rowRefresh;

  assign rowRefresh = fullFlag | rowDirty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // refresh-all flag: set by reset or request, dropped when a pass ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    fullFlag <= 1'b1;
    else if (refreshAll)          fullFlag <= 1'b1;
    else if (state == ST_FINISH)  fullFlag <= 1'b0;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.clear = 1'b1;
          stateNext    = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!regPending) begin
          if (rowsDone) begin
            if (runOpen) strobe.closeRun = 1'b1;
            else         stateNext       = ST_DRAIN;
          end else if (rowRefresh) begin
            strobe.markRow = 1'b1;
            stateNext      = ST_PIXELS;
          end else if (runOpen) begin
            strobe.closeRun = 1'b1;
          end else begin
            strobe.skipRow = 1'b1;
          end
        end
      end
      ST_PIXELS: begin
        strobe.issue = 1'b1;
        if (lastCol) stateNext = ST_CHECK;
      end
      ST_DRAIN: begin
        if (pipeEmpty) stateNext = ST_FINISH;
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign eof  = (state == ST_FINISH);

  AST_STALL_ON_REGION: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> !regPending); // R6

  AST_EOF_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    eof |-> pipeEmpty && !regPending && !runOpen); // R9

  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(eof)); // R8

  AST_EOF_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    eof |=> !eof); // R8

endmodule

// File: rtl/palScan.sv
module palScan
  import palScanPkg::*;
#(
  parameter int WIDTH  = 640,
  parameter int HEIGHT = 480,
  localparam int PIX_TOTAL = WIDTH * HEIGHT,
  localparam int VA_W  = (PIX_TOTAL > 1) ? $clog2(PIX_TOTAL) : 1,
  localparam int ROW_W = $clog2(HEIGHT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             refreshAll,
  output logic [ROW_W-1:0] rowSel,
  input  logic             rowDirty,
  output logic             vmRd,
  output logic [VA_W-1:0]  vmAddr,
  input  logic [7:0]       vmData,
  output logic             palRd,
  output logic [7:0]       palIdx,
  input  logic [23:0]      palRgb,
  output logic             pixValid,
  output logic [VA_W-1:0]  pixAddr,
  output logic [31:0]      pixData,
  output logic             regValid,
  input  logic             regReady,
  output logic [ROW_W-1:0] regStart,
  output logic [ROW_W-1:0] regCount,
  output logic             busy,
  output logic             eof
);

  scanStrobe_t strobe;
  logic lastCol, rowsDone, runOpen, pipeEmpty;

  palScanCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .refreshAll (refreshAll),
    .rowDirty   (rowDirty),
    .lastCol    (lastCol),
    .rowsDone   (rowsDone),
    .runOpen    (runOpen),
    .regPending (regValid),
    .pipeEmpty  (pipeEmpty),
    .strobe     (strobe),
    .busy       (busy),
    .eof        (eof)
  );

  palScanDatapath #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .lastCol    (lastCol),
    .rowsDone   (rowsDone),
    .runOpen    (runOpen),
    .regPending (regValid),
    .pipeEmpty  (pipeEmpty),
    .rowSel     (rowSel),
    .vmRd       (vmRd),
    .vmAddr     (vmAddr),
    .vmData     (vmData),
    .palRd      (palRd),
    .palIdx     (palIdx),
    .palRgb     (palRgb),
    .pixValid   (pixValid),
    .pixAddr    (pixAddr),
    .pixData    (pixData),
    .regReady   (regReady),
    .regStart   (regStart),
    .regCount   (regCount)
  );

endmodule

// File: tb/palScan_bench.sv
`timescale 1ns/1ps
module palScan_bench;

  localparam int BW = 4;
  localparam int BH = 6;
  localparam int NPIX = BW * BH;
  localparam int VA_W = $clog2(NPIX);
  localparam int ROW_W = $clog2(BH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic refreshAll = 1'b0;
  logic [ROW_W-1:0] rowSel;
  logic rowDirty;
  logic vmRd, palRd, pixValid, regValid, regReady, busy, eof;
  logic [VA_W-1:0] vmAddr, pixAddr;
  logic [7:0] vmData = 8'h00;
  logic [7:0] palIdx;
  logic [23:0] palRgb = 24'h0;
  logic [31:0] pixData;
  logic [ROW_W-1:0] regStart, regCount;

  always #5 clk = ~clk;

  palScan #(.WIDTH(BW), .HEIGHT(BH)) u_palScan (
    .clk(clk), .rstN(rstN), .start(start), .refreshAll(refreshAll),
    .rowSel(rowSel), .rowDirty(rowDirty),
    .vmRd(vmRd), .vmAddr(vmAddr), .vmData(vmData),
    .palRd(palRd), .palIdx(palIdx), .palRgb(palRgb),
    .pixValid(pixValid), .pixAddr(pixAddr), .pixData(pixData),
    .regValid(regValid), .regReady(regReady),
    .regStart(regStart), .regCount(regCount),
    .busy(busy), .eof(eof)
  );

  int vecCount = 0;
  int missCount = 0;

  function automatic logic [7:0] memByte(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [23:0] palOf(logic [7:0] i);
    return {i ^ 8'h5A, i + 8'd3, ~i};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory and palette models, one cycle of latency each
  always @(posedge clk) begin
    if (vmRd)  vmData <= memByte(int'(vmAddr));
    if (palRd) palRgb <= palOf(palIdx);
  end

  // dirty bits and region consumer
  logic [7:0] dirtyMask = 8'h00;
  int readyDelay = 0;
  int waitCnt = 0;
  assign rowDirty = dirtyMask[rowSel];
  assign regReady = regValid && (waitCnt >= readyDelay);
  always @(posedge clk) begin
    if (regValid && regReady)  waitCnt <= 0;
    else if (regValid)         waitCnt <= waitCnt + 1;
  end

  // expected results for the current pass
  logic [7:0] expRows;
  int expA [NPIX];
  int expD [NPIX];
  int expRs [BH];
  int expRc [BH];
  int expPixN, expRegN;
  int pixIdx, regIdx, eofCnt;
  bit monOn = 1'b0;

  always @(negedge clk) begin
    if (monOn) begin
      if (pixValid) begin
        if (pixIdx < expPixN) begin
          check(int'(pixAddr) == expA[pixIdx], "R1 pixel address", int'(pixAddr), expA[pixIdx]);
          check(int'(pixData) == expD[pixIdx], "R1 packed pixel", int'(pixData), expD[pixIdx]);
        end else begin
          check(1'b0, "R2 unexpected extra pixel", int'(pixAddr), -1);
        end
        pixIdx++;
      end
      if (vmRd) begin
        automatic int rowOf = int'(vmAddr) / BW;
        check(expRows[rowOf], "R3 read issued for clean row", rowOf, -1);
        check(!regValid, "R6 read issued while region pending", 1, 0);
      end
      if (regValid && regReady) begin
        if (regIdx < expRegN) begin
          check(int'(regStart) == expRs[regIdx], "R4 region start", int'(regStart), expRs[regIdx]);
          check(int'(regCount) == expRc[regIdx], "R4 region count", int'(regCount), expRc[regIdx]);
        end else begin
          check(1'b0, "R4 unexpected region", int'(regStart), -1);
        end
        regIdx++;
      end
      if (eof) begin
        eofCnt++;
        check(pixIdx == expPixN, "R9 pixels before eof", pixIdx, expPixN);
        check(regIdx == expRegN, "R5 regions before eof", regIdx, expRegN);
        check(busy, "R8 busy during eof", 0, 1);
      end
    end
  end

  task automatic runPass(input logic [7:0] mask, input int delay, input bit full, input bit extraStart);
    bit open = 1'b0;
    int rs = 0;
    expPixN = 0;
    expRegN = 0;
    for (int r = 0; r < BH; r++) begin
      expRows[r] = full | mask[r];
      if (expRows[r]) begin
        for (int c = 0; c < BW; c++) begin
          expA[expPixN] = r * BW + c;
          expD[expPixN] = int'({8'h00, palOf(memByte(r * BW + c))});
          expPixN++;
        end
        if (!open) begin open = 1'b1; rs = r; end
      end else if (open) begin
        expRs[expRegN] = rs; expRc[expRegN] = r - rs; expRegN++;
        open = 1'b0;
      end
    end
    expRows[7:BH] = '0;
    if (open) begin
      expRs[expRegN] = rs; expRc[expRegN] = BH - rs; expRegN++;
    end
    pixIdx = 0; regIdx = 0; eofCnt = 0;
    dirtyMask = mask;
    readyDelay = delay;
    monOn = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    #1 check(busy, "R8 busy after start", int'(busy), 1);
    if (extraStart) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    do begin @(negedge clk); #1; end while (eofCnt == 0);
    @(negedge clk); #1;
    check(!busy, "R8 busy low after eof", int'(busy), 0);
    repeat (8) @(negedge clk);
    #1;
    check(!busy && eofCnt == 1, "R8 exactly one pass", eofCnt, 1);
    check(pixIdx == expPixN, "R2 converted pixel total", pixIdx, expPixN);
    check(regIdx == expRegN, "R4 region total", regIdx, expRegN);
    monOn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !eof && !regValid && !pixValid && !vmRd, "R8 reset state", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R7: flag set from reset converts every row; extra start ignored (R8)
    runPass(8'b0000_0101, 0, 1'b1, 1'b1);
    // R7: flag cleared, no dirty rows -> nothing converted
    runPass(8'h00, 0, 1'b0, 1'b0);
    // R7: request sets the flag again
    @(negedge clk); refreshAll = 1'b1;
    @(negedge clk); refreshAll = 1'b0;
    runPass(8'h00, 2, 1'b1, 1'b0);
    // R2 R3 R4 R5 R6: every dirty pattern, varying consumer delay
    for (int m = 0; m < (1 << BH); m++) begin
      runPass(8'(m), m % 3, 1'b0, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vecCount++;
    missCount++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule